// File: doc/BRIEF.md
# Eight-Input ADC Scan Controller

This block sequences one-shot conversions over up to eight analog inputs. Software programs it through a 32-bit memory-mapped register bus. The registers select a channel bitmask, a sampling period, interrupt enables and the interrupt output style. Software then sets the enable bit. The controller walks the selected inputs from the lowest index to the highest. For each input it waits the sampling period plus a fixed conversion time, counted in conversion-clock ticks. It then takes a 12-bit code from a behavioural sample port and stores it in that input's result register. It also raises a per-channel completion flag, and when the flag is enabled it signals the interrupt line.

The sample port stands in for the analog converter and uses a valid/ready handshake. The controller raises `smp_ready` with the channel index on `smp_ch` once the channel's conversion time has elapsed. It holds both steady until the source asserts `smp_valid`, and the code is captured on the first clock edge where both are high. A source that keeps `smp_valid` low stalls the scan; no timing is lost and no code is dropped. Software can abort a scan by clearing the enable bit. If software sets enable while the bitmask is empty, the block raises an error flag instead of converting.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, control word 0x00 reads 0, timing word 0x0C reads 0x000E0578, divider word 0x28 reads 4, status word 0x24 reads 0, and `irq` and `smp_ready` are 0.
- R2: Configuration words read back what was written, limited to their defined bits, and every other bit reads 0. Word 0x00 keeps bit 2 (power) and bit 15 (soft-reset release). Word 0x04 keeps bits 0, 2, 4, 12 and 13. Word 0x20 keeps bits 7:0, 16 and 31. Word 0x2C keeps all 32 bits.
- R3: The divider word (bits 8:0 at 0x28) accepts only the value 4. A write of any other value leaves it unchanged.
- R4: Writing 1 to bit 0 of word 0x00 while the bitmask at 0x08 (bits 7:0) is nonzero starts a scan. Bits 0 and 1 of word 0x00 then read 1 until the scan ends, and afterwards read 0. Selected channels are converted in ascending index order. With `smp_valid` held high, the scan lasts N*((P+6)*4+1) clock cycles, where N is the number of selected channels and P is the sampling period in bits 15:0 of word 0x0C.
- R5: The result word of channel n, at 0x30+4n, holds the captured 12-bit code in bits 11:0 with the upper bits 0. Channels that were not converted keep their previous result.
- R6: While `smp_ready` is high and `smp_valid` is low, `smp_ready` stays high and `smp_ch` stays stable, and the scan does not advance.
- R7: Status bit n (n in 0..7) is set when channel n's code is captured. Status bit 16 is set by the error of R8. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R8: Setting enable while the bitmask is zero starts no conversion. Busy stays 0, `smp_ready` stays 0, and status bit 16 is set.
- R9: Writing 0 to bit 0 of word 0x00 during a scan stops it on that clock edge. No further codes are captured and no further status bits are set.
- R10: With bit 31 of word 0x20 set to 1 (level mode), `irq` is high exactly while some status bit n is set with enable bit n set, or while status bit 16 is set with enable bit 16 set.
- R11: With bit 31 of word 0x20 set to 0 (pulse mode), each enabled completion or error event gives a one-cycle `irq` pulse on the cycle after the event. Disabled events give none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of a 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, valid while `bus_en` is high and `bus_we` is low) |
| smp_ready | output | 1 | Controller is waiting for the code of `smp_ch` |
| smp_ch | output | 3 | Channel whose code is requested |
| smp_valid | input | 1 | Source presents a code on `smp_code` |
| smp_code | input | 12 | Conversion code from the behavioural source |
| irq | output | 1 | Interrupt, as a pulse or a level depending on the mode |

## Verification
The scan is run with single low and high channels, with sparse and alternating bitmasks, and with the full bitmask. Each run uses a different sampling period. The exact busy duration tells apart errors in the tick count and in the divider. The order in which channels are captured exposes a wrong priority in the channel walk, and rereading all eight result words after every run catches writes to the wrong channel. Directed runs then cover the remaining behaviour: a stalled source, an abort in the middle of a scan, an enable with an empty mask, and the two interrupt styles with enabled and disabled channels.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  // word offsets that software relies on
  localparam logic [ADDR_W-1:0] OFS_CTL0  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CTL1  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CHSEL = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_TIME  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_IRQC  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_DIV   = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_FILT  = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_RES0  = 8'h30;

  localparam logic [DATA_W-1:0] CTL1_MASK  = 32'h0000_3015;
  localparam logic [DATA_W-1:0] TIME_RESET = 32'h000E_0578;

  typedef enum logic [1:0] {
    SC_IDLE = 2'd0,
    SC_CONV = 2'd1,
    SC_HAND = 2'd2
  } scan_st_e;
endpackage

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NCH        = 8,
  parameter int CODE_W     = 12,
  parameter int DIV_W      = 9,
  parameter int SMP_W      = 16,
  parameter int CONV_TICKS = 6,
  localparam int CH_W      = $clog2(NCH),
  localparam int CNT_W     = SMP_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [NCH-1:0]    chmask,
  input  logic [SMP_W-1:0]  smp_per,
  input  logic [DIV_W-1:0]  div_val,
  output logic              busy,
  output logic              smp_ready,
  output logic [CH_W-1:0]   smp_ch,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] smp_code,
  output logic              res_we,
  output logic [CH_W-1:0]   res_ch,
  output logic [CODE_W-1:0] res_code,
  output logic              done
);
  scan_st_e         st_q;
  logic [NCH-1:0]   pend_q;
  logic [CH_W-1:0]  cur_q;
  logic [DIV_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic [NCH-1:0]   rest;
  logic             tick;

  function automatic logic [CH_W-1:0] lowest(input logic [NCH-1:0] m);
    lowest = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (m[i]) lowest = CH_W'(i);
  endfunction

  assign rest      = pend_q & ~(NCH'(1) << cur_q);
  assign tick      = (pre_q == div_val - DIV_W'(1));
  assign busy      = (st_q != SC_IDLE);
  assign smp_ready = (st_q == SC_HAND);
  assign smp_ch    = cur_q;
  assign res_we    = smp_ready && smp_valid;
  assign res_ch    = cur_q;
  assign res_code  = smp_code;
  assign done      = res_we && (rest == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SC_IDLE;
      pend_q <= '0;
      cur_q  <= '0;
      pre_q  <= '0;
      cnt_q  <= '0;
      lim_q  <= '0;
    end else if (abort) begin
      st_q   <= SC_IDLE;
      pend_q <= '0;
    end else begin
      case (st_q)
        SC_IDLE: if (start) begin
          pend_q <= chmask;
          cur_q  <= lowest(chmask);
          pre_q  <= '0;
          cnt_q  <= '0;
          lim_q  <= CNT_W'(smp_per) + CNT_W'(CONV_TICKS);
          st_q   <= SC_CONV;
        end
        SC_CONV: begin
          if (tick) begin
            pre_q <= '0;
            if (cnt_q == lim_q - CNT_W'(1)) begin
              cnt_q <= '0;
              st_q  <= SC_HAND;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end else begin
            pre_q <= pre_q + DIV_W'(1);
          end
        end
        SC_HAND: if (smp_valid) begin
          pend_q <= rest;
          if (rest != '0) begin
            cur_q <= lowest(rest);
            pre_q <= '0;
            cnt_q <= '0;
            st_q  <= SC_CONV;
          end else begin
            st_q <= SC_IDLE;
          end
        end
        default: st_q <= SC_IDLE;
      endcase
    end
  end

  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_ready && !smp_valid && !abort) |=> (smp_ready && $stable(smp_ch))); // R6
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !busy); // R4
endmodule

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
  import adc_scan_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int CODE_W   = 12,
  parameter int DIV_W    = 9,
  parameter int SMP_W    = 16,
  parameter int DIV_ONLY = 4,
  localparam int CH_W    = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              res_we,
  input  logic [CH_W-1:0]   res_ch,
  input  logic [CODE_W-1:0] res_code,
  output logic              start,
  output logic              abort,
  output logic              err_evt,
  output logic [NCH-1:0]    chmask,
  output logic [SMP_W-1:0]  smp_per,
  output logic [DIV_W-1:0]  div_val,
  output logic              irq_lvl,
  output logic [NCH-1:0]    irq_ch_en,
  output logic              irq_err_en,
  output logic [NCH-1:0]    stat_ch,
  output logic              stat_err
);
  logic              wr;
  logic              pwr_q, srel_q;
  logic [DATA_W-1:0] ctl1_q, time_q, filt_q;
  logic [NCH-1:0]    mask_q, ien_q;
  logic              eien_q, lvl_q;
  logic [DIV_W-1:0]  div_q;
  logic              stat_err_q;
  logic [NCH-1:0]    stat_q;
  logic [CODE_W-1:0] res_q [NCH];

  assign wr      = bus_en && bus_we;
  assign start   = wr && (bus_addr == OFS_CTL0) && bus_wdata[0] && !busy && (mask_q != '0);
  assign err_evt = wr && (bus_addr == OFS_CTL0) && bus_wdata[0] && !busy && (mask_q == '0);
  assign abort   = wr && (bus_addr == OFS_CTL0) && !bus_wdata[0] && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q  <= 1'b0;
      srel_q <= 1'b0;
      ctl1_q <= '0;
      mask_q <= '0;
      time_q <= TIME_RESET;
      ien_q  <= '0;
      eien_q <= 1'b0;
      lvl_q  <= 1'b0;
      div_q  <= DIV_W'(DIV_ONLY);
      filt_q <= '0;
    end else if (wr) begin
      case (bus_addr)
        OFS_CTL0: begin
          pwr_q  <= bus_wdata[2];
          srel_q <= bus_wdata[15];
        end
        OFS_CTL1:  ctl1_q <= bus_wdata & CTL1_MASK;
        OFS_CHSEL: mask_q <= bus_wdata[NCH-1:0];
        OFS_TIME:  time_q <= bus_wdata;
        OFS_IRQC: begin
          ien_q  <= bus_wdata[NCH-1:0];
          eien_q <= bus_wdata[16];
          lvl_q  <= bus_wdata[31];
        end
        OFS_DIV:  if (bus_wdata[DIV_W-1:0] == DIV_W'(DIV_ONLY)) div_q <= bus_wdata[DIV_W-1:0];
        OFS_FILT: filt_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  // status: capture/error set wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_err_q <= 1'b0;
    else if (err_evt) stat_err_q <= 1'b1;
    else if (wr && (bus_addr == OFS_STAT) && bus_wdata[16]) stat_err_q <= 1'b0;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[g] <= 1'b0;
      else if (res_we && (res_ch == CH_W'(g))) stat_q[g] <= 1'b1;
      else if (wr && (bus_addr == OFS_STAT) && bus_wdata[g]) stat_q[g] <= 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_q[g] <= '0;
      else if (res_we && (res_ch == CH_W'(g))) res_q[g] <= res_code;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      case (bus_addr)
        OFS_CTL0: begin
          bus_rdata[0]  = busy;
          bus_rdata[1]  = busy;
          bus_rdata[2]  = pwr_q;
          bus_rdata[15] = srel_q;
        end
        OFS_CTL1:  bus_rdata = ctl1_q;
        OFS_CHSEL: bus_rdata[NCH-1:0] = mask_q;
        OFS_TIME:  bus_rdata = time_q;
        OFS_IRQC: begin
          bus_rdata[NCH-1:0] = ien_q;
          bus_rdata[16]      = eien_q;
          bus_rdata[31]      = lvl_q;
        end
        OFS_STAT: begin
          bus_rdata[NCH-1:0] = stat_q;
          bus_rdata[16]      = stat_err_q;
        end
        OFS_DIV:  bus_rdata[DIV_W-1:0] = div_q;
        OFS_FILT: bus_rdata = filt_q;
        default: begin
          for (int i = 0; i < NCH; i++)
            if (bus_addr == ADDR_W'(OFS_RES0 + 4 * i)) bus_rdata[CODE_W-1:0] = res_q[i];
        end
      endcase
    end
  end

  assign chmask     = mask_q;
  assign smp_per    = time_q[SMP_W-1:0];
  assign div_val    = div_q;
  assign irq_lvl    = lvl_q;
  assign irq_ch_en  = ien_q;
  assign irq_err_en = eien_q;
  assign stat_ch    = stat_q;
  assign stat_err   = stat_err_q;

  AST_DIV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == DIV_W'(DIV_ONLY))); // R3
  AST_ERR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (bus_addr == OFS_STAT) && bus_wdata[16] && !err_evt) |=> !stat_err_q); // R7
  AST_ZERO_NOSTART: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> !busy); // R8
endmodule

// File: rtl/adc_scan_irq.sv
module adc_scan_irq #(
  parameter int NCH   = 8,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lvl,
  input  logic [NCH-1:0]  ch_en,
  input  logic            err_en,
  input  logic [NCH-1:0]  stat_ch,
  input  logic            stat_err,
  input  logic            res_we,
  input  logic [CH_W-1:0] res_ch,
  input  logic            err_evt,
  output logic            irq
);
  logic evt;
  logic pulse_q;

  assign evt = (res_we && ch_en[res_ch]) || (err_evt && err_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= evt;
  end

  assign irq = lvl ? (((stat_ch & ch_en) != '0) || (stat_err && err_en)) : pulse_q;

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !lvl) |-> $past(res_we || err_evt)); // R11
  AST_LEVEL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl && stat_err && err_en) |-> irq); // R10
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NCH        = 8,
  parameter int CODE_W     = 12,
  parameter int DIV_W      = 9,
  parameter int SMP_W      = 16,
  parameter int DIV_ONLY   = 4,
  parameter int CONV_TICKS = 6,
  localparam int CH_W      = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              smp_ready,
  output logic [CH_W-1:0]   smp_ch,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] smp_code,
  output logic              irq
);
  logic              busy, start, abort, err_evt, done;
  logic              res_we;
  logic [CH_W-1:0]   res_ch;
  logic [CODE_W-1:0] res_code;
  logic [NCH-1:0]    chmask, irq_ch_en, stat_ch;
  logic [SMP_W-1:0]  smp_per;
  logic [DIV_W-1:0]  div_val;
  logic              irq_lvl, irq_err_en, stat_err;

  adc_scan_regs #(
    .NCH(NCH), .CODE_W(CODE_W), .DIV_W(DIV_W), .SMP_W(SMP_W), .DIV_ONLY(DIV_ONLY)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .res_we(res_we), .res_ch(res_ch), .res_code(res_code),
    .start(start), .abort(abort), .err_evt(err_evt),
    .chmask(chmask), .smp_per(smp_per), .div_val(div_val),
    .irq_lvl(irq_lvl), .irq_ch_en(irq_ch_en), .irq_err_en(irq_err_en),
    .stat_ch(stat_ch), .stat_err(stat_err)
  );

  adc_scan_seq #(
    .NCH(NCH), .CODE_W(CODE_W), .DIV_W(DIV_W), .SMP_W(SMP_W), .CONV_TICKS(CONV_TICKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(start), .abort(abort), .chmask(chmask), .smp_per(smp_per), .div_val(div_val),
    .busy(busy), .smp_ready(smp_ready), .smp_ch(smp_ch),
    .smp_valid(smp_valid), .smp_code(smp_code),
    .res_we(res_we), .res_ch(res_ch), .res_code(res_code), .done(done)
  );

  adc_scan_irq #(.NCH(NCH)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .lvl(irq_lvl), .ch_en(irq_ch_en), .err_en(irq_err_en),
    .stat_ch(stat_ch), .stat_err(stat_err),
    .res_we(res_we), .res_ch(res_ch), .err_evt(err_evt),
    .irq(irq)
  );

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort) |=> (busy && !done)); // R4
endmodule

// File: tb/adc_scan_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_scan_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        smp_ready;
  logic [2:0]  smp_ch;
  logic        smp_valid;
  logic [11:0] smp_code;
  logic        irq;

  logic        vld_on = 1'b1;
  logic [7:0]  cur_tag = 8'h00;
  int          total = 0, bad = 0;
  int          ord [16];
  int          ord_n = 0;
  int          irq_cnt = 0;
  logic [11:0] exp_res [8];
  bit          finished = 0;

  always #4 clk = ~clk;

  assign smp_valid = vld_on;
  assign smp_code  = {cur_tag, 1'b1, smp_ch};

  adc_scan_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .smp_ready(smp_ready), .smp_ch(smp_ch),
    .smp_valid(smp_valid), .smp_code(smp_code),
    .irq(irq)
  );

  always @(negedge clk) begin
    if (smp_ready && smp_valid && ord_n < 16) begin
      ord[ord_n] = int'(smp_ch);
      ord_n = ord_n + 1;
    end
    if (irq) irq_cnt = irq_cnt + 1;
  end

  // {mask, sampling period, tag}
  localparam logic [31:0] VTAB [6] = '{
    {8'h01, 16'd2, 8'h11},
    {8'h80, 16'd0, 8'h22},
    {8'hA5, 16'd1, 8'h33},
    {8'hFF, 16'd3, 8'h44},
    {8'h5A, 16'd2, 8'h55},
    {8'h18, 16'd5, 8'h66}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic run(input logic [7:0] m, input logic [15:0] p, input logic [7:0] tag, output int cyc);
    logic [31:0] v;
    wr(8'h08, {24'h0, m});
    wr(8'h0C, {16'h000E, p});
    cur_tag = tag;
    ord_n = 0;
    wr(8'h00, 32'h0000_8005);
    cyc = 0;
    rd(8'h00, v);
    while (v[1] && cyc < 100000) begin
      cyc++;
      @(negedge clk);
      rd(8'h00, v);
    end
  endtask

  initial begin
    #(8ns * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int cyc, k, n;
    for (int i = 0; i < 8; i++) exp_res[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, v); chk("R1 ctl0", v, 32'h0);
    rd(8'h0C, v); chk("R1 timing", v, 32'h000E_0578);
    rd(8'h28, v); chk("R1 div", v, 32'd4);
    rd(8'h24, v); chk("R1 status", v, 32'h0);
    chk("R1 irq/ready", {30'h0, irq, smp_ready}, 32'h0);

    // R2 readback and reserved bits
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); chk("R2 ctl1", v, 32'h0000_3015);
    wr(8'h00, 32'hFFFF_FFFE); rd(8'h00, v); chk("R2 ctl0", v, 32'h0000_8004);
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, v); chk("R2 irqctl", v, 32'h8001_00FF);
    wr(8'h2C, 32'h1234_5678); rd(8'h2C, v); chk("R2 filter", v, 32'h1234_5678);
    wr(8'h20, 32'h0);

    // R3 divider accepts only 4
    wr(8'h28, 32'd7); rd(8'h28, v); chk("R3 div rejects 7", v, 32'd4);
    wr(8'h28, 32'd4); rd(8'h28, v); chk("R3 div keeps 4", v, 32'd4);

    // vector table: R4 timing/order, R5 results, R7 status
    for (int t = 0; t < 6; t++) begin
      logic [7:0]  m;
      logic [15:0] p;
      logic [7:0]  tg;
      m = VTAB[t][31:24]; p = VTAB[t][23:8]; tg = VTAB[t][7:0];
      run(m, p, tg, cyc);
      n = $countones(m);
      chk("R4 busy duration", cyc, n * ((int'(p) + 6) * 4 + 1));
      rd(8'h00, v); chk("R4 enable/busy cleared", v & 32'h3, 32'h0);
      k = 0;
      for (int c = 0; c < 8; c++) begin
        if (m[c]) begin
          chk("R4 ascending order", ord[k], c);
          k++;
          exp_res[c] = {tg, 1'b1, 3'(c)};
        end
      end
      for (int c = 0; c < 8; c++) begin
        rd(8'(8'h30 + 4 * c), v);
        chk("R5 result word", v, {20'h0, exp_res[c]});
      end
      rd(8'h24, v); chk("R7 status flags", v, {24'h0, m});
      wr(8'h24, 32'hFFFF_FFFF);
      rd(8'h24, v); chk("R7 w1c all", v, 32'h0);
    end

    // R6 stalled source
    vld_on = 1'b0;
    wr(8'h08, 32'h08);
    wr(8'h0C, 32'h000E_0000);
    cur_tag = 8'h77;
    wr(8'h00, 32'h0000_8005);
    k = 0;
    while (!smp_ready && k < 1000) begin k++; @(negedge clk); end
    chk("R6 ready channel", {29'h0, smp_ch}, 32'd3);
    repeat (10) @(negedge clk);
    chk("R6 ready held", {28'h0, smp_ready, smp_ch}, 32'h0B);
    rd(8'h00, v); chk("R6 still busy", v & 32'h3, 32'h3);
    vld_on = 1'b1;
    @(negedge clk);
    rd(8'h00, v); chk("R6 done after valid", v & 32'h3, 32'h0);
    exp_res[3] = {8'h77, 1'b1, 3'd3};
    rd(8'h3C, v); chk("R6 captured code", v, {20'h0, exp_res[3]});
    wr(8'h24, 32'hFFFF_FFFF);

    // R9 abort mid-scan
    wr(8'h08, 32'hFF);
    wr(8'h0C, 32'h000E_0002);
    cur_tag = 8'h88;
    wr(8'h00, 32'h0000_8005);
    repeat (40) @(negedge clk);
    wr(8'h00, 32'h0);
    rd(8'h00, v); chk("R9 busy dropped", v & 32'h3, 32'h0);
    exp_res[0] = {8'h88, 1'b1, 3'd0};
    repeat (200) @(negedge clk);
    rd(8'h24, v); chk("R9 only first channel", v, 32'h01);
    rd(8'h34, v); chk("R9 channel 1 untouched", v, {20'h0, exp_res[1]});
    chk("R9 no request", {31'h0, smp_ready}, 32'h0);
    wr(8'h24, 32'hFFFF_FFFF);

    // R10 level interrupt
    wr(8'h20, 32'h8000_0004);
    chk("R10 idle low", {31'h0, irq}, 32'h0);
    run(8'h04, 16'd1, 8'h99, cyc);
    chk("R10 level high", {31'h0, irq}, 32'h1);
    wr(8'h24, 32'h0);
    rd(8'h24, v); chk("R7 write 0 keeps", v, 32'h04);
    chk("R10 still high", {31'h0, irq}, 32'h1);
    wr(8'h24, 32'h04);
    chk("R10 low after clear", {31'h0, irq}, 32'h0);
    run(8'h02, 16'd1, 8'h9A, cyc);
    rd(8'h24, v); chk("R10 disabled flag set", v, 32'h02);
    chk("R10 disabled stays low", {31'h0, irq}, 32'h0);
    wr(8'h24, 32'hFFFF_FFFF);

    // R11 pulse interrupt
    wr(8'h20, 32'h0000_0004);
    irq_cnt = 0;
    run(8'h06, 16'd1, 8'hAB, cyc);
    repeat (5) @(negedge clk);
    chk("R11 single pulse", irq_cnt, 1);
    chk("R11 back low", {31'h0, irq}, 32'h0);
    wr(8'h24, 32'hFFFF_FFFF);

    // R8 empty mask
    wr(8'h20, 32'h8001_0000);
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h0000_8005);
    rd(8'h00, v); chk("R8 not busy", v & 32'h3, 32'h0);
    chk("R8 no request", {31'h0, smp_ready}, 32'h0);
    rd(8'h24, v); chk("R8 error flag", v, 32'h0001_0000);
    chk("R8 irq level", {31'h0, irq}, 32'h1);
    wr(8'h24, 32'h0001_0000);
    rd(8'h24, v); chk("R7 error w1c", v, 32'h0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule